// File: doc/BRIEF.md
# Sprite Page Copy Engine

This block moves one page of bytes from the CPU's address space into sprite attribute memory. The CPU writes a page number into the trigger register; the engine then stops the CPU, waits through one or two alignment cycles, and copies the page byte by byte. Each byte is first fetched with a bus read and then pushed, on the next cycle, into the sprite memory's data port.

The destination address is not held here. It lives in a separate sprite address register that advances on every data-port write. The copy therefore lands at whatever that register holds when the transfer starts, and it wraps around the end of sprite memory. A `done` pulse tells the rest of the system that the CPU has been released.

Top module: `spr_page_dma`

## Requirements
- R1: After reset, `cpu_halt`, `bus_rd`, `spr_we` and `done` are all 0.
- R2: A trigger write sampled while `odd_cycle` is 0 raises `cpu_halt` on the next cycle. `cpu_halt` then stays high for exactly 513 consecutive cycles.
- R3: A trigger write sampled while `odd_cycle` is 1 holds `cpu_halt` high for exactly 514 consecutive cycles.
- R4: The first 1 halted cycle (when `odd_cycle` was 0) or the first 2 halted cycles (when it was 1) have neither `bus_rd` nor `spr_we` asserted.
- R5: After the alignment cycles come 256 read cycles (`bus_rd`=1) and 256 write cycles (`spr_we`=1), strictly alternating and starting with a read. No cycle has both.
- R6: Read number i (0..255) uses `bus_addr` = {trigger byte, i[7:0]}, so the reads cover the page in ascending order.
- R7: The `spr_wdata` of each write cycle equals the `bus_rdata` sampled in the read cycle just before it.
- R8: The sprite address register advances once per write. With a start value S, byte i of the page therefore ends up at sprite location (S+i) mod 256.
- R9: A trigger write that arrives while `cpu_halt` is high is ignored: the page, the length and the data of the running copy are unchanged, and no second copy follows.
- R10: `done` is high for exactly one cycle, the first cycle in which `cpu_halt` is low after a copy.
- R11: `bus_rd` and `spr_we` are only ever asserted while `cpu_halt` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_we | input | 1 | CPU write strobe for the trigger register |
| trig_data | input | 8 | Page number written with the trigger |
| odd_cycle | input | 1 | High when the current CPU cycle is odd |
| cpu_halt | output | 1 | Holds the CPU while a copy runs |
| bus_addr | output | 16 | Source address during read cycles |
| bus_rd | output | 1 | Bus read strobe |
| bus_rdata | input | 8 | Data returned by the bus in the read cycle |
| spr_we | output | 1 | Write strobe to the sprite data port |
| spr_wdata | output | 8 | Byte written to the sprite data port |
| done | output | 1 | One-cycle pulse when the CPU is released |

## Verification
Two events can fall in the same cycle: the end of a copy and a new trigger write. A trigger placed in the final write cycle lands while the engine is still busy, so it must be dropped; the bench checks this by seeing that no halt follows. A trigger placed in the `done` cycle lands after the engine has gone idle, so it must start a new copy at once, and the bench checks the full length, addresses and data of that copy. Random pages, parities and start addresses, together with triggers dropped into the middle of a copy, test the ordering and the wrap-around in the sprite memory model.

// File: rtl/spd_pkg.sv
package spd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_RD,
        ST_WR
    } spd_state_e;

    typedef struct packed {
        spd_state_e state;
        logic       extra;
        logic       done;
    } spd_ctrl_s;

endpackage

// File: rtl/spd_ctrl.sv
module spd_ctrl
    import spd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_we,
    input  logic odd_cycle,
    input  logic last_byte,
    output logic busy,
    output logic load,
    output logic rd_phase,
    output logic wr_phase,
    output logic done
);

    spd_ctrl_s ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (trig_we) begin
                    ctrl_d.state = ST_ALIGN;
                    ctrl_d.extra = odd_cycle;
                end
            end
            ST_ALIGN: begin
                if (ctrl_q.extra) begin
                    ctrl_d.extra = 1'b0;
                end else begin
                    ctrl_d.state = ST_RD;
                end
            end
            ST_RD: begin
                ctrl_d.state = ST_WR;
            end
            ST_WR: begin
                if (last_byte) begin
                    ctrl_d.state = ST_IDLE;
                    ctrl_d.done  = 1'b1;
                end else begin
                    ctrl_d.state = ST_RD;
                end
            end
            default: begin
                ctrl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{state: ST_IDLE, extra: 1'b0, done: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign busy     = (ctrl_q.state != ST_IDLE);
    assign load     = (ctrl_q.state == ST_IDLE) && trig_we;
    assign rd_phase = (ctrl_q.state == ST_RD);
    assign wr_phase = (ctrl_q.state == ST_WR);
    assign done     = ctrl_q.done;

endmodule

// File: rtl/spd_addr.sv
module spd_addr #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 8,
    localparam int PAGE_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PAGE_W-1:0] page_in,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last_byte
);

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [IDX_W-1:0]  idx;
    } addr_s;

    addr_s addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load) begin
            addr_d.page = page_in;
            addr_d.idx  = '0;
        end else if (step) begin
            addr_d.idx = addr_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr      = {addr_q.page, addr_q.idx};
    assign last_byte = &addr_q.idx;

endmodule

// File: rtl/spd_hold.sv
module spd_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (cap) begin
            hold_d = din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign dout = hold_q;

endmodule

// File: rtl/spr_page_dma.sv
module spr_page_dma #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 8,
    localparam int PAGE_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_we,
    input  logic [PAGE_W-1:0] trig_data,
    input  logic              odd_cycle,
    output logic              cpu_halt,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              spr_we,
    output logic [DATA_W-1:0] spr_wdata,
    output logic              done
);

    logic load, rd_phase, wr_phase, last_byte;

    spd_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_we   (trig_we),
        .odd_cycle (odd_cycle),
        .last_byte (last_byte),
        .busy      (cpu_halt),
        .load      (load),
        .rd_phase  (rd_phase),
        .wr_phase  (wr_phase),
        .done      (done)
    );

    spd_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) addr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .page_in   (trig_data),
        .step      (wr_phase),
        .addr      (bus_addr),
        .last_byte (last_byte)
    );

    spd_hold #(.DATA_W(DATA_W)) hold_i (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (rd_phase),
        .din   (bus_rdata),
        .dout  (spr_wdata)
    );

    assign bus_rd = rd_phase;
    assign spr_we = wr_phase;

endmodule

// File: rtl/spd_checker.sv
module spd_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 8,
    localparam int PAGE_N  = 1 << IDX_W,
    localparam int LEN_EV  = 2 * PAGE_N + 1,
    localparam int LEN_OD  = 2 * PAGE_N + 2,
    localparam int RUN_W   = $clog2(LEN_OD + 1) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_halt,
    input logic              bus_rd,
    input logic              spr_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] spr_wdata,
    input logic              done
);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (cpu_halt) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    assert_rd_wr_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && spr_we));

    assert_rd_then_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> spr_we);

    assert_wdata_R7: assert property (@(posedge clk) disable iff (!rst_n)
        spr_we |-> spr_wdata == $past(bus_rdata));

    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && $past(spr_we)) |->
            (bus_addr[IDX_W-1:0] == $past(bus_addr[IDX_W-1:0]) + 1'b1) &&
            (bus_addr[ADDR_W-1:IDX_W] == $past(bus_addr[ADDR_W-1:IDX_W])));

    assert_halted_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || spr_we) |-> cpu_halt);

    assert_done_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!cpu_halt && $past(spr_we)));

    assert_fell_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_halt) |-> done);

    assert_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_q == RUN_W'(LEN_EV) || run_q == RUN_W'(LEN_OD)));

endmodule

bind spr_page_dma spd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_halt  (cpu_halt),
    .bus_rd    (bus_rd),
    .spr_we    (spr_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .spr_wdata (spr_wdata),
    .done      (done)
);

// File: tb/spr_page_dma_tb.sv
`timescale 1ns/1ps
module spr_page_dma_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_we = 1'b0;
    logic [7:0]  trig_data = '0;
    logic        odd_cycle = 1'b0;
    logic        cpu_halt, bus_rd, spr_we, done;
    logic [15:0] bus_addr;
    logic [7:0]  bus_rdata, spr_wdata;

    int errors = 0;
    int checks = 0;

    logic [7:0] smem [256];
    logic [7:0] sptr;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] src_fn(input logic [15:0] a);
        return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5A;
    endfunction

    assign bus_rdata = src_fn(bus_addr);

    spr_page_dma dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_we   (trig_we),
        .trig_data (trig_data),
        .odd_cycle (odd_cycle),
        .cpu_halt  (cpu_halt),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .spr_we    (spr_we),
        .spr_wdata (spr_wdata),
        .done      (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Called at a negedge; leaves at the negedge of the done cycle.
    task automatic run_xfer(input logic [7:0] page, input bit odd, input logic [7:0] start,
                            input bit mid_trig, input bit end_trig);
        int idle = odd ? 2 : 1;
        int n = 0;
        int bad_idle = 0, bad_seq = 0, bad_addr = 0, bad_data = 0, bad_mem = 0;
        int a_act = 0, a_exp = 0, d_act = 0, d_exp = 0;
        sptr = start;
        trig_we = 1'b1; trig_data = page; odd_cycle = odd;
        @(negedge clk);
        trig_we = 1'b0; odd_cycle = 1'b0;
        check(cpu_halt === 1'b1, odd ? "R3" : "R2", "halt after trigger", cpu_halt, 1);
        while (cpu_halt === 1'b1 && n < 600) begin
            int k;
            n++;
            k = n - idle - 1;
            if (n <= idle) begin
                if (bus_rd || spr_we) bad_idle++;
            end else if (k % 2 == 0) begin
                if (!bus_rd || spr_we) bad_seq++;
                if (bus_addr !== {page, 8'(k / 2)}) begin
                    if (bad_addr == 0) begin a_act = bus_addr; a_exp = {page, 8'(k / 2)}; end
                    bad_addr++;
                end
            end else begin
                if (!spr_we || bus_rd) bad_seq++;
                if (spr_wdata !== src_fn({page, 8'((k - 1) / 2)})) begin
                    if (bad_data == 0) begin d_act = spr_wdata; d_exp = src_fn({page, 8'((k - 1) / 2)}); end
                    bad_data++;
                end
                smem[sptr] = spr_wdata;
                sptr = sptr + 1'b1;
            end
            if (mid_trig && n == 100) begin
                trig_we = 1'b1; trig_data = ~page; odd_cycle = ~odd;
            end else if (end_trig && n == idle + 512) begin
                trig_we = 1'b1; trig_data = page ^ 8'h11; odd_cycle = 1'b0;
            end else begin
                trig_we = 1'b0; odd_cycle = 1'b0;
            end
            @(negedge clk);
        end
        trig_we = 1'b0;
        check(n == 512 + idle, odd ? "R3" : "R2", "halt length", n, 512 + idle);
        check(bad_idle == 0, "R4", "strobes in alignment cycles", bad_idle, 0);
        check(bad_seq == 0, "R5", "read/write alternation errors", bad_seq, 0);
        check(bad_addr == 0, mid_trig ? "R9" : "R6", "first bad read address", a_act, a_exp);
        check(bad_data == 0, "R7", "first bad write data", d_act, d_exp);
        for (int i = 0; i < 256; i++) begin
            if (smem[8'(start + i)] !== src_fn({page, 8'(i)})) bad_mem++;
        end
        check(bad_mem == 0 && sptr == start, "R8", "misplaced sprite bytes", bad_mem, 0);
        check(done === 1'b1 && cpu_halt === 1'b0, "R10", "done on release cycle", done, 1);
    endtask

    task automatic quiet(input int cycles, input string req);
        int bad = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (done || cpu_halt || bus_rd || spr_we) bad++;
        end
        check(bad == 0, req, "activity while idle", bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!cpu_halt && !bus_rd && !spr_we && !done, "R1", "reset outputs",
              {cpu_halt, bus_rd, spr_we, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cpu_halt && !done, "R1", "idle after reset", {cpu_halt, done}, 0);

        // directed: even parity, sprite pointer 0
        run_xfer(8'h02, 1'b0, 8'h00, 1'b0, 1'b0);
        quiet(3, "R10");
        // directed: odd parity, wrapping start, trigger in the middle (ignored)
        run_xfer(8'hC7, 1'b1, 8'hF3, 1'b1, 1'b0);
        quiet(2, "R9");
        // trigger in last write cycle must be ignored
        run_xfer(8'h40, 1'b0, 8'h81, 1'b0, 1'b1);
        quiet(4, "R9");
        // back to back: trigger issued in the done cycle starts a copy
        run_xfer(8'h10, 1'b1, 8'h7F, 1'b0, 1'b0);
        run_xfer(8'hFF, 1'b0, 8'hFF, 1'b0, 1'b0);
        quiet(2, "R11");

        void'($urandom(32'd4242));
        for (int t = 0; t < 6; t++) begin
            logic [7:0] pg = 8'($urandom);
            bit od = 1'($urandom);
            logic [7:0] st = 8'($urandom);
            bit mt = 1'($urandom);
            run_xfer(pg, od, st, mt, 1'b0);
            quiet(1 + int'($urandom % 3), "R11");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule